// File: doc/BRIEF.md
# Micro-Step Instruction-Cycle Controller

This block is the control unit and datapath of a small single-accumulator processor. Each clock performs one elementary register transfer. The state is held in a program counter, an instruction register, a memory address register, a memory buffer register and one accumulator. A two-bit phase code records which part of the instruction cycle is running: fetch, indirect, execute or interrupt. Fetch, indirect and interrupt each follow one fixed sequence of steps. Execute follows a separate timed sequence for each implemented opcode. In some of those steps two transfers happen at once, and in one step a conditional skip is combined with a memory write.

The processor is connected to a word memory with a clocked write and a read that returns data in the same cycle as the address. The memory address always comes from the memory address register, and the write data always comes from the memory buffer register. The phase code, the program counter and the accumulator are brought out so that the instruction cycle can be followed from outside the block.

Top module: `micro_step_cpu`

## Requirements
- R1: While reset is low at a clock edge, the block sets the program counter and the accumulator to 0, sets the phase code to fetch, enables interrupts and keeps the memory write strobe low.
- R2: The phase codes are fetch = 00, indirect = 01, execute = 10 and interrupt = 11. Fetch lasts 3 clocks. It reads the word at the program counter, adds 1 to the program counter and loads the instruction register. The next phase is indirect when bit 15 of the fetched word is 1, and execute when that bit is 0.
- R3: Indirect lasts 3 clocks. It reads the word at the address field (bits 11:0) and replaces the address field with the low 12 bits of that word. The next phase is execute.
- R4: Opcode 1 (bits 14:12) is ADD and lasts 3 execute clocks. It adds the word at the address to the accumulator, modulo 2^16.
- R5: Opcode 2 is ISZ and lasts 4 execute clocks. It writes the word at the address plus 1, modulo 2^16, back to the same address. The write happens only in the fourth clock.
- R6: In the ISZ write-back clock, when the incremented word is 0, the program counter is increased by 1 in that same clock. This skips the next instruction.
- R7: Opcode 3 is BSA and lasts 3 execute clocks. In its second clock it writes the program counter value held at the start of execute to the address and loads the address into the program counter. In its third clock the program counter becomes the address plus 1, modulo 2^12.
- R8: Opcodes 0, 4, 5, 6 and 7 are no-ops. Each takes 1 execute clock and changes no memory word, the accumulator or the program counter.
- R9: At the end of execute, when the interrupt request is high and interrupts are enabled, the next phase is interrupt. Interrupt lasts 2 clocks. It writes the program counter to address 0, sets the program counter to 1, disables interrupts and returns to fetch.
- R10: Once interrupts are disabled, a high interrupt request is ignored and execute returns to fetch.
- R11: The memory write strobe is high only in the ISZ write-back clock, the BSA second clock and the interrupt second clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | 16 | Read data for the word at mem_addr |
| mem_addr | output | 12 | Memory word address (memory address register) |
| mem_wdata | output | 16 | Memory write data (memory buffer register) |
| mem_we | output | 1 | Memory write strobe |
| cyc_code | output | 2 | Current instruction-cycle phase |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |

## Verification
Some properties are checked by assertions on every clock. These are: the step count stays within each phase's length, the routing after fetch follows the indirect flag, indirect always leads to execute and interrupt always leads back to fetch, writes occur only in execute or interrupt, a BSA write carries the current program counter, an ISZ zero write-back increments the program counter, and the accumulator changes only in the ADD final step. The disabled interrupt state is also checked to stay disabled.

Other results can only be shown by the bench's scenarios. These are the arithmetic results across swept operands, the exact clock in which each sequence finishes or writes, the wrap of the program counter and of the data word, the no-op opcodes leaving memory untouched, and the one interrupt entry per reset with the return address it saves.

// File: rtl/cpu_mseq_pkg.sv
// Package: shared types for the micro-step processor.
// It defines the phase code encoding, the selector encodings for each register source,
// the datapath control word and the opcode values.
// Assumes the instruction word layout is: indirect flag in the MSB, then the opcode field, then the address field.
package cpu_mseq_pkg;

    localparam int OP_W   = 3;
    localparam int STEP_W = 2;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_INDIR = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INTR  = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        MAR_KEEP,
        MAR_FROM_PC,
        MAR_FROM_IR,
        MAR_CLEAR
    } mar_src_e;

    typedef enum logic [1:0] {
        MBR_KEEP,
        MBR_FROM_MEM,
        MBR_PLUS1,
        MBR_FROM_PC
    } mbr_src_e;

    typedef enum logic [1:0] {
        PC_KEEP,
        PC_STEP,
        PC_FROM_IR,
        PC_VECTOR
    } pc_op_e;

    typedef struct packed {
        mar_src_e mar_src;
        mbr_src_e mbr_src;
        pc_op_e   pc_op;
        logic     ir_load;
        logic     ir_addr_load;
        logic     acc_add;
        logic     skip_if_zero;
        logic     ie_clear;
    } dp_ctrl_t;

    localparam logic [OP_W-1:0] OPC_ADD = 3'd1;
    localparam logic [OP_W-1:0] OPC_ISZ = 3'd2;
    localparam logic [OP_W-1:0] OPC_BSA = 3'd3;

endpackage

// File: rtl/cpu_phase_seq.sv
// Module: phase sequencer.
// It holds the two-bit phase code and the step counter inside the current phase.
// Assumes the decoder raises 'last' in the final step of every sequence and gives the next phase with it.
module cpu_phase_seq
    import cpu_mseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last,
    input  cyc_e              next_cyc,
    output cyc_e              cyc,
    output logic [STEP_W-1:0] step
);

    // Advance the step each clock; move to the next phase after a final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc  <= CYC_FETCH;
            step <= '0;
        end else if (last) begin
            cyc  <= next_cyc;
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end

    // Fetch, indirect and interrupt never exceed three steps.
    assert_step_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != CYC_EXEC) |-> (step <= 2'd2));

    // Indirect always hands over to execute.
    assert_indir_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc) == CYC_INDIR && cyc != CYC_INDIR) |-> (cyc == CYC_EXEC));

    // Interrupt always returns to fetch.
    assert_intr_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc) == CYC_INTR && cyc != CYC_INTR) |-> (cyc == CYC_FETCH));

endmodule

// File: rtl/cpu_uop_decode.sv
// Module: micro-operation decoder.
// It maps (phase, step, opcode) to the register transfers for the current clock.
// Assumes MBR holds the fetched word during the final fetch step, so the indirect flag is read from MBR.
module cpu_uop_decode
    import cpu_mseq_pkg::*;
(
    input  cyc_e              cyc,
    input  logic [STEP_W-1:0] step,
    input  logic [OP_W-1:0]   opcode,
    input  logic              mbr_msb,
    input  logic              irq_take,
    output dp_ctrl_t          dp,
    output logic              mem_wr,
    output logic              last,
    output cyc_e              next_cyc
);

    cyc_e exec_exit;

    // Choose the phase that follows an execute sequence.
    always_comb exec_exit = irq_take ? CYC_INTR : CYC_FETCH;

    // Produce the transfer set for one step.
    always_comb begin
        dp       = '0;
        mem_wr   = 1'b0;
        last     = 1'b0;
        next_cyc = cyc;
        case (cyc)
            CYC_FETCH: begin
                case (step)
                    2'd0: dp.mar_src = MAR_FROM_PC;
                    2'd1: begin
                        dp.mbr_src = MBR_FROM_MEM;
                        dp.pc_op   = PC_STEP;
                    end
                    default: begin
                        dp.ir_load = 1'b1;
                        last       = 1'b1;
                        next_cyc   = mbr_msb ? CYC_INDIR : CYC_EXEC;
                    end
                endcase
            end
            CYC_INDIR: begin
                case (step)
                    2'd0: dp.mar_src = MAR_FROM_IR;
                    2'd1: dp.mbr_src = MBR_FROM_MEM;
                    default: begin
                        dp.ir_addr_load = 1'b1;
                        last            = 1'b1;
                        next_cyc        = CYC_EXEC;
                    end
                endcase
            end
            CYC_EXEC: begin
                case (opcode)
                    OPC_ADD: begin
                        case (step)
                            2'd0: dp.mar_src = MAR_FROM_IR;
                            2'd1: dp.mbr_src = MBR_FROM_MEM;
                            default: begin
                                dp.acc_add = 1'b1;
                                last       = 1'b1;
                                next_cyc   = exec_exit;
                            end
                        endcase
                    end
                    OPC_ISZ: begin
                        case (step)
                            2'd0: dp.mar_src = MAR_FROM_IR;
                            2'd1: dp.mbr_src = MBR_FROM_MEM;
                            2'd2: dp.mbr_src = MBR_PLUS1;
                            default: begin
                                mem_wr          = 1'b1;
                                dp.skip_if_zero = 1'b1;
                                last            = 1'b1;
                                next_cyc        = exec_exit;
                            end
                        endcase
                    end
                    OPC_BSA: begin
                        case (step)
                            2'd0: begin
                                dp.mar_src = MAR_FROM_IR;
                                dp.mbr_src = MBR_FROM_PC;
                            end
                            2'd1: begin
                                dp.pc_op = PC_FROM_IR;
                                mem_wr   = 1'b1;
                            end
                            default: begin
                                dp.pc_op = PC_STEP;
                                last     = 1'b1;
                                next_cyc = exec_exit;
                            end
                        endcase
                    end
                    default: begin
                        last     = 1'b1;
                        next_cyc = exec_exit;
                    end
                endcase
            end
            CYC_INTR: begin
                case (step)
                    2'd0: begin
                        dp.mar_src = MAR_CLEAR;
                        dp.mbr_src = MBR_FROM_PC;
                    end
                    default: begin
                        mem_wr      = 1'b1;
                        dp.pc_op    = PC_VECTOR;
                        dp.ie_clear = 1'b1;
                        last        = 1'b1;
                        next_cyc    = CYC_FETCH;
                    end
                endcase
            end
            default: begin
                last     = 1'b1;
                next_cyc = CYC_FETCH;
            end
        endcase
    end

endmodule

// File: rtl/cpu_datapath.sv
// Module: register datapath.
// It holds PC, IR, MAR, MBR, the accumulator and the interrupt enable, and applies one control word per clock.
// Assumes mem_rdata is valid for the word at MAR in the same clock (combinational read).
module cpu_datapath
    import cpu_mseq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dp_ctrl_t          dp,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar,
    output logic [WORD_W-1:0] mbr,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] acc,
    output logic [OP_W-1:0]   ir_op,
    output logic              ir_ind,
    output logic              ie
);

    localparam int PAD_W = WORD_W - ADDR_W;

    logic [WORD_W-1:0] ir;
    logic              mbr_zero;

    always_comb mbr_zero = (mbr == '0);
    always_comb ir_op    = ir[WORD_W-2 -: OP_W];
    always_comb ir_ind   = ir[WORD_W-1];

    // Load the memory address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
        end else begin
            case (dp.mar_src)
                MAR_FROM_PC: mar <= pc;
                MAR_FROM_IR: mar <= ir[ADDR_W-1:0];
                MAR_CLEAR:   mar <= '0;
                default:     mar <= mar;
            endcase
        end
    end

    // Load the memory buffer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr <= '0;
        end else begin
            case (dp.mbr_src)
                MBR_FROM_MEM: mbr <= mem_rdata;
                MBR_PLUS1:    mbr <= mbr + 1'b1;
                MBR_FROM_PC:  mbr <= {{PAD_W{1'b0}}, pc};
                default:      mbr <= mbr;
            endcase
        end
    end

    // Update the program counter, including the ISZ conditional skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            case (dp.pc_op)
                PC_STEP:    pc <= pc + 1'b1;
                PC_FROM_IR: pc <= ir[ADDR_W-1:0];
                PC_VECTOR:  pc <= ADDR_W'(1);
                default:    pc <= (dp.skip_if_zero && mbr_zero) ? pc + 1'b1 : pc;
            endcase
        end
    end

    // Load the whole instruction register, or only its address field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir <= '0;
        end else if (dp.ir_load) begin
            ir <= mbr;
        end else if (dp.ir_addr_load) begin
            ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
        end
    end

    // Add the buffer register into the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (dp.acc_add) begin
            acc <= acc + mbr;
        end
    end

    // Interrupt enable: set at reset, cleared when an interrupt is entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie <= 1'b1;
        end else if (dp.ie_clear) begin
            ie <= 1'b0;
        end
    end

    // The accumulator changes only in the ADD final step.
    assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dp.acc_add |=> (acc == $past(acc)));

    // Once disabled, interrupts stay disabled until reset.
    assert_ie_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> !ie);

endmodule

// File: rtl/micro_step_cpu.sv
// Module: top of the micro-step processor.
// It connects the phase sequencer, the micro-operation decoder and the register datapath to the memory port.
// Assumes a word memory with a clocked write and a same-cycle read at mem_addr.
module micro_step_cpu
    import cpu_mseq_pkg::*;
#(
    parameter  int WORD_W = 16,
    localparam int ADDR_W = WORD_W - 1 - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [1:0]        cyc_code,
    output logic [ADDR_W-1:0] pc_o,
    output logic [WORD_W-1:0] acc_o
);

    cyc_e              cyc;
    cyc_e              next_cyc;
    logic [STEP_W-1:0] step;
    logic              last;
    logic              mem_wr;
    dp_ctrl_t          dp;
    logic [ADDR_W-1:0] mar;
    logic [WORD_W-1:0] mbr;
    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] acc;
    logic [OP_W-1:0]   ir_op;
    logic              ir_ind;
    logic              ie;
    logic              irq_take;

    always_comb irq_take = irq && ie;

    cpu_phase_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .last     (last),
        .next_cyc (next_cyc),
        .cyc      (cyc),
        .step     (step)
    );

    cpu_uop_decode u_dec (
        .cyc      (cyc),
        .step     (step),
        .opcode   (ir_op),
        .mbr_msb  (mbr[WORD_W-1]),
        .irq_take (irq_take),
        .dp       (dp),
        .mem_wr   (mem_wr),
        .last     (last),
        .next_cyc (next_cyc)
    );

    cpu_datapath #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .dp        (dp),
        .mem_rdata (mem_rdata),
        .mar       (mar),
        .mbr       (mbr),
        .pc        (pc),
        .acc       (acc),
        .ir_op     (ir_op),
        .ir_ind    (ir_ind),
        .ie        (ie)
    );

    // Drive the memory and observation ports.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        mem_we    = mem_wr;
        cyc_code  = cyc;
        pc_o      = pc;
        acc_o     = acc;
    end

    // Writes happen only in execute or interrupt.
    assert_we_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (cyc == CYC_EXEC || cyc == CYC_INTR));

    // After fetch, the route follows the indirect flag of the loaded instruction.
    assert_fetch_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_FETCH && step == 2'd2) |=> (cyc == (ir_ind ? CYC_INDIR : CYC_EXEC)));

    // A BSA write stores the current program counter as the return address.
    assert_bsa_retaddr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cyc == CYC_EXEC && ir_op == OPC_BSA) |-> (mem_wdata[ADDR_W-1:0] == pc));

    // A zero ISZ write-back advances the program counter by one in the same clock.
    assert_isz_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && cyc == CYC_EXEC && ir_op == OPC_ISZ && mem_wdata == '0)
            |=> (pc_o == $past(pc_o) + 1'b1));

    // Leaving interrupt lands on the vector with interrupts disabled.
    assert_intr_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc) == CYC_INTR && cyc == CYC_FETCH) |-> (pc == ADDR_W'(1) && !ie));

endmodule

// File: tb/tb_micro_step_cpu.sv
// Bench: runs short programs from reset and sweeps operands, opcodes and addresses.
// Expected values are computed arithmetically from the requirements.
module tb_micro_step_cpu;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [1:0]  cyc_code;
    logic [11:0] pc_o;
    logic [15:0] acc_o;

    logic [15:0] mem [4096];
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    int          we_cnt;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    micro_step_cpu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .cyc_code  (cyc_code),
        .pc_o      (pc_o),
        .acc_o     (acc_o)
    );

    // Word memory: bench loading port has priority, then the processor's write.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr];

    // Count processor writes since reset.
    always @(posedge clk) begin
        if (!rst_n) we_cnt <= 0;
        else if (mem_we) we_cnt <= we_cnt + 1;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic begin_test(input logic irq_v);
        @(negedge clk);
        rst_n = 1'b0;
        ld_en = 1'b0;
        irq   = irq_v;
        @(posedge clk);
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_addr = a;
        ld_data = d;
        @(posedge clk);
    endtask

    task automatic go();
        @(negedge clk);
        ld_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reset();
        begin_test(1'b0);
        poke(12'h000, 16'h0000);
        @(negedge clk);
        chk("R1", "pc", 32'(pc_o), 32'h0);
        chk("R1", "acc", 32'(acc_o), 32'h0);
        chk("R1", "phase", 32'(cyc_code), 32'h0);
        chk("R1", "we", 32'(mem_we), 32'h0);
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        check_reset();

        // R4 / R2: two ADDs across swept operands, with wrap.
        for (int i = 0; i < 32; i++) begin
            logic [15:0] a, b;
            a = 16'(i * 16'h1357 + 3);
            b = 16'(16'hFFFF - i * 16'h0F0F);
            begin_test(1'b0);
            poke(12'h000, 16'h1100);
            poke(12'h001, 16'h1101);
            poke(12'h100, a);
            poke(12'h101, b);
            go();
            step(3);
            chk("R2", "phase after fetch", 32'(cyc_code), 32'h2);
            chk("R2", "pc after fetch", 32'(pc_o), 32'h1);
            step(3);
            chk("R4", "acc after first ADD", 32'(acc_o), 32'(a));
            chk("R4", "phase after ADD", 32'(cyc_code), 32'h0);
            step(6);
            chk("R4", "acc sum", 32'(acc_o), 32'(16'(a + b)));
            chk("R4", "pc", 32'(pc_o), 32'h2);
            chk("R11", "no writes in ADD", 32'(we_cnt), 32'h0);
        end

        check_reset();

        // R5 / R6: ISZ over boundary and swept values.
        for (int i = 0; i < 24; i++) begin
            logic [15:0] v, r;
            case (i)
                0:       v = 16'hFFFF;
                1:       v = 16'hFFFE;
                2:       v = 16'h0000;
                3:       v = 16'h7FFF;
                default: v = 16'(i * 16'h0B31);
            endcase
            r = v + 16'h1;
            begin_test(1'b0);
            poke(12'h000, 16'h2200);
            poke(12'h001, 16'h0000);
            poke(12'h002, 16'h0000);
            poke(12'h200, v);
            go();
            step(6);
            chk("R5", "word before write step", 32'(mem[12'h200]), 32'(v));
            chk("R5", "phase still execute", 32'(cyc_code), 32'h2);
            step(1);
            chk("R5", "incremented word", 32'(mem[12'h200]), 32'(r));
            chk("R6", "pc after skip test", 32'(pc_o), (r == 16'h0) ? 32'h2 : 32'h1);
            chk("R11", "one write", 32'(we_cnt), 32'h1);
        end

        // R7: BSA over swept targets, including the top address.
        for (int i = 0; i < 8; i++) begin
            logic [11:0] x;
            x = (i == 7) ? 12'hFFF : 12'(12'h010 + i * 12'h1F3);
            begin_test(1'b0);
            poke(12'h000, 16'h3000 | 16'(x));
            poke(x, 16'hDEAD);
            go();
            step(4);
            chk("R7", "no write in first step", 32'(mem[x]), 32'h0000DEAD);
            step(1);
            chk("R7", "return address", 32'(mem[x]), 32'h1);
            chk("R7", "pc at target", 32'(pc_o), 32'(x));
            step(1);
            chk("R7", "pc target plus one", 32'(pc_o), 32'(12'(x + 12'h1)));
            chk("R7", "phase", 32'(cyc_code), 32'h0);
        end

        // R7: BSA from a non-zero location saves that location plus one.
        begin_test(1'b0);
        poke(12'h000, 16'h0000);
        poke(12'h001, 16'h30C0);
        go();
        step(10);
        chk("R7", "return address from 1", 32'(mem[12'h0C0]), 32'h2);
        chk("R7", "pc", 32'(pc_o), 32'h0C1);

        // R8: unimplemented opcodes are one-clock no-ops.
        for (int op = 0; op < 8; op++) begin
            if (op >= 1 && op <= 3) continue;
            begin_test(1'b0);
            poke(12'h000, 16'(op << 12) | 16'h0123);
            poke(12'h001, 16'h0000);
            poke(12'h123, 16'h5A5A);
            go();
            step(3);
            chk("R8", "phase execute", 32'(cyc_code), 32'h2);
            step(1);
            chk("R8", "back to fetch", 32'(cyc_code), 32'h0);
            chk("R8", "pc", 32'(pc_o), 32'h1);
            chk("R8", "acc", 32'(acc_o), 32'h0);
            chk("R8", "word untouched", 32'(mem[12'h123]), 32'h5A5A);
            chk("R11", "no writes", 32'(we_cnt), 32'h0);
        end

        // R3: indirect ADD through several pointers.
        for (int j = 0; j < 4; j++) begin
            logic [11:0] p, t;
            logic [15:0] v;
            p = 12'(12'h050 + j * 12'h011);
            t = 12'(12'h300 + j * 12'h123);
            v = 16'(16'h4321 + j * 16'h1111);
            begin_test(1'b0);
            poke(12'h000, 16'h9000 | 16'(p));
            poke(p, 16'hA000 | 16'(t));
            poke(t, v);
            go();
            step(3);
            chk("R3", "phase indirect", 32'(cyc_code), 32'h1);
            step(3);
            chk("R3", "phase execute", 32'(cyc_code), 32'h2);
            step(3);
            chk("R3", "acc via pointer", 32'(acc_o), 32'(v));
            chk("R3", "pc", 32'(pc_o), 32'h1);
        end

        // R3 / R7: indirect BSA.
        begin_test(1'b0);
        poke(12'h000, 16'hB050);
        poke(12'h050, 16'h0400);
        go();
        step(9);
        chk("R3", "BSA return address", 32'(mem[12'h400]), 32'h1);
        chk("R3", "BSA pc", 32'(pc_o), 32'h401);

        // R3 / R6: indirect ISZ with skip.
        begin_test(1'b0);
        poke(12'h000, 16'hA050);
        poke(12'h050, 16'h0600);
        poke(12'h600, 16'hFFFF);
        poke(12'h001, 16'h0000);
        go();
        step(10);
        chk("R6", "indirect ISZ word", 32'(mem[12'h600]), 32'h0);
        chk("R6", "indirect ISZ pc", 32'(pc_o), 32'h2);

        // R9 / R10: interrupt after a no-op, then ignored once disabled.
        begin_test(1'b1);
        poke(12'h000, 16'h0000);
        poke(12'h001, 16'h0000);
        poke(12'h002, 16'h0000);
        go();
        step(4);
        chk("R9", "phase interrupt", 32'(cyc_code), 32'h3);
        step(2);
        chk("R9", "phase fetch", 32'(cyc_code), 32'h0);
        chk("R9", "pc vector", 32'(pc_o), 32'h1);
        chk("R9", "saved pc", 32'(mem[12'h000]), 32'h1);
        chk("R11", "one write", 32'(we_cnt), 32'h1);
        step(4);
        chk("R10", "no second interrupt", 32'(cyc_code), 32'h0);
        chk("R10", "pc", 32'(pc_o), 32'h2);
        chk("R10", "no new writes", 32'(we_cnt), 32'h1);

        // R9: interrupt after ADD.
        begin_test(1'b1);
        poke(12'h000, 16'h1100);
        poke(12'h100, 16'h0005);
        go();
        step(6);
        chk("R9", "phase after ADD", 32'(cyc_code), 32'h3);
        chk("R9", "acc", 32'(acc_o), 32'h5);
        step(2);
        chk("R9", "saved pc after ADD", 32'(mem[12'h000]), 32'h1);
        chk("R9", "pc vector", 32'(pc_o), 32'h1);

        // R9 / R6: interrupt after a skipping ISZ saves the skipped pc.
        begin_test(1'b1);
        poke(12'h000, 16'h2200);
        poke(12'h200, 16'hFFFF);
        go();
        step(7);
        chk("R9", "phase after ISZ", 32'(cyc_code), 32'h3);
        step(2);
        chk("R9", "saved skipped pc", 32'(mem[12'h000]), 32'h2);
        chk("R9", "pc vector", 32'(pc_o), 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule